// File: doc/BRIEF.md
# FIFO Stall Timeout Interrupt Unit

This block sits beside the transmit and receive FIFOs of an audio serial port. It watches both directions for stalls. A free-running prescaler divides the system clock into a coarse tick. Its period is a base count of 88000 divided by a power of two that software selects. For each direction, a stall counter advances once per tick while that direction is running and its FIFO moves no data. When the counter reaches a programmed threshold, a one-shot "hung" event is raised for that direction.

The hung events and the two per-direction done pulses go to a four-source interrupt controller. Each source has a raw bit, an enable bit, a masked status bit (raw AND enable) and a write-one-to-clear trigger. The four masked bits are ORed into one interrupt line. Software writes the enable and clear vectors through two write strobes. The threshold, tick scale and global timeout enable are static configuration inputs. Recommended values after reset are a threshold of 16 and the enable set to 1.

Top module: `fifo_stall_irq`

## Requirements
- R1: After reset, `irq_raw_o`, `irq_ena_o` and `irq_st_o` are all zero and `irq_o` is 0.
- R2: The tick prescaler restarts when its count is greater than or equal to `TICK_BASE >> tmo_shift_i`. The tick period is therefore that limit plus one cycle, and a larger shift gives a proportionally shorter timeout.
- R3: While a direction is active (`dir_act_i[d]`, index 0 = receive, 1 = transmit) and makes no transfer, its stall counter advances once per tick. When the counter reaches `tmo_thr_i`, a hung event sets raw bit 2 (receive) or raw bit 3 (transmit).
- R4: A FIFO transfer strobe or a direction reset on a direction returns its stall counter to zero, so the full threshold of ticks must elapse again before a hung event.
- R5: No hung event is produced while `tmo_en_i` is 0 or while the direction is inactive.
- R6: A hung event fires once per stall. Once the raw bit is cleared, it stays clear while the same stall persists. It fires again only after activity resumes and a new stall reaches the threshold.
- R7: A pulse on `rx_done_i` sets raw bit 0, and a pulse on `tx_done_i` sets raw bit 1, one cycle later.
- R8: `irq_st_o` equals the raw bits ANDed with the enable bits written through `irq_ena_we_i`. `irq_o` is the OR of the four masked bits.
- R9: A clear write sets to 0 every raw bit whose clear-vector bit is 1. Raw bits whose clear-vector bit is 0 keep their value.
- R10: When a set event and a clear write hit the same raw bit in the same cycle, the bit ends up set.
- R11: The two directions time out independently. A stall on one direction never sets the other direction's hung bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | Receive-done pulse |
| tx_done_i | input | 1 | Transmit-done pulse |
| dir_act_i | input | 2 | Direction running (0 receive, 1 transmit) |
| fifo_xfer_i | input | 2 | FIFO transfer strobe per direction |
| dir_rst_i | input | 2 | Direction reset per direction |
| tmo_en_i | input | 1 | Global stall timeout enable |
| tmo_thr_i | input | 8 | Stall threshold in ticks |
| tmo_shift_i | input | 3 | Tick period scale (base >> shift) |
| irq_ena_we_i | input | 1 | Enable vector write strobe |
| irq_ena_i | input | 4 | Enable vector write data |
| irq_clr_we_i | input | 1 | Clear vector write strobe |
| irq_clr_i | input | 4 | Clear vector write data (write one to clear) |
| irq_raw_o | output | 4 | Raw interrupt status |
| irq_ena_o | output | 4 | Interrupt enable bits |
| irq_st_o | output | 4 | Masked interrupt status |
| irq_o | output | 1 | Combined interrupt line |

## Verification
The interrupt controller is driven by a vector table. The table mixes done pulses, enable writes and clear writes with all-zero, partial and full masks, and one vector makes a set and a clear collide on the same bit. This separates masking from clearing and shows which of the two wins. Stall timing is checked against early and late windows derived from the tick period. Runs with two shift values tell a correct prescaler limit from an unscaled one. Periodic transfer strobes, a mid-stall direction reset, a disabled timeout and an idle direction each show whether the counter restarts or holds where it should. A persisting stall after a clear checks that the hung event does not repeat.

// File: rtl/stall_irq_pkg.sv
package stall_irq_pkg;
  localparam int unsigned NSRC = 4;
  localparam int unsigned NDIR = 2;
  localparam int unsigned DIR_RX = 0;
  localparam int unsigned DIR_TX = 1;
  // raw/enable/status bit positions
  localparam int unsigned SRC_RX_DONE = 0;
  localparam int unsigned SRC_TX_DONE = 1;
  localparam int unsigned SRC_RX_HUNG = 2;
  localparam int unsigned SRC_TX_HUNG = 3;
endpackage

// File: rtl/stall_tick_gen.sv
module stall_tick_gen #(
  parameter int unsigned BASE    = 88000,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               tick_o
);
  localparam int unsigned CNT_W = $clog2(BASE + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit  = CNT_W'(BASE >> shift_i);
  assign tick_o = en_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && limit != '0 && $stable(shift_i)) |=> !tick_o); // R2
endmodule

// File: rtl/stall_watch.sv
module stall_watch #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic             act_i,
  input  logic             xfer_i,
  input  logic             dir_rst_i,
  input  logic [TMO_W-1:0] thr_i,
  output logic             hung_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             fired_q;
  logic             restart;

  assign restart = dir_rst_i | xfer_i | ~act_i | ~en_i;
  // one-shot: counter parks at threshold, fired_q blocks repeats
  assign hung_o  = ~restart & (cnt_q >= thr_i) & ~fired_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else if (restart) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
    end else begin
      if (tick_i && cnt_q < thr_i) cnt_q <= cnt_q + 1'b1;
      if (hung_o)                  fired_q <= 1'b1;
    end
  end

  AST_HUNG_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hung_o |=> !hung_o); // R6
  AST_XFER_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_i || dir_rst_i) |=> (cnt_q == '0)); // R4
endmodule

// File: rtl/stall_irq_ctrl.sv
module stall_irq_ctrl #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         ena_we_i,
  input  logic [N-1:0] ena_wdata_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_wdata_i,
  output logic [N-1:0] raw_o,
  output logic [N-1:0] ena_o,
  output logic [N-1:0] st_o
);
  logic [N-1:0] raw_q, ena_q, clr_vec;

  assign clr_vec = clr_we_i ? clr_wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      ena_q <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_vec) | set_i;  // set beats clear
      if (ena_we_i) ena_q <= ena_wdata_i;
    end
  end

  assign raw_o = raw_q;
  assign ena_o = ena_q;
  assign st_o  = raw_q & ena_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> raw_q[i]); // R10
    AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_vec[i] && !set_i[i]) |=> !raw_q[i]); // R9
    AST_RAW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_vec[i] && !set_i[i]) |=> $stable(raw_q[i])); // R9
  end
endmodule

// File: rtl/fifo_stall_irq.sv
module fifo_stall_irq
  import stall_irq_pkg::*;
#(
  parameter int unsigned TICK_BASE = 88000,
  parameter int unsigned SHIFT_W   = 3,
  parameter int unsigned TMO_W     = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_done_i,
  input  logic               tx_done_i,
  input  logic [NDIR-1:0]    dir_act_i,
  input  logic [NDIR-1:0]    fifo_xfer_i,
  input  logic [NDIR-1:0]    dir_rst_i,
  input  logic               tmo_en_i,
  input  logic [TMO_W-1:0]   tmo_thr_i,
  input  logic [SHIFT_W-1:0] tmo_shift_i,
  input  logic               irq_ena_we_i,
  input  logic [NSRC-1:0]    irq_ena_i,
  input  logic               irq_clr_we_i,
  input  logic [NSRC-1:0]    irq_clr_i,
  output logic [NSRC-1:0]    irq_raw_o,
  output logic [NSRC-1:0]    irq_ena_o,
  output logic [NSRC-1:0]    irq_st_o,
  output logic               irq_o
);
  logic            tick;
  logic [NDIR-1:0] hung;
  logic [NSRC-1:0] set_vec;

  stall_tick_gen #(.BASE(TICK_BASE), .SHIFT_W(SHIFT_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (tmo_en_i),
    .shift_i (tmo_shift_i),
    .tick_o  (tick)
  );

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    stall_watch #(.TMO_W(TMO_W)) u_watch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .en_i      (tmo_en_i),
      .act_i     (dir_act_i[d]),
      .xfer_i    (fifo_xfer_i[d]),
      .dir_rst_i (dir_rst_i[d]),
      .thr_i     (tmo_thr_i),
      .hung_o    (hung[d])
    );
  end

  always_comb begin
    set_vec              = '0;
    set_vec[SRC_RX_DONE] = rx_done_i;
    set_vec[SRC_TX_DONE] = tx_done_i;
    set_vec[SRC_RX_HUNG] = hung[DIR_RX];
    set_vec[SRC_TX_HUNG] = hung[DIR_TX];
  end

  stall_irq_ctrl #(.N(NSRC)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_vec),
    .ena_we_i    (irq_ena_we_i),
    .ena_wdata_i (irq_ena_i),
    .clr_we_i    (irq_clr_we_i),
    .clr_wdata_i (irq_clr_i),
    .raw_o       (irq_raw_o),
    .ena_o       (irq_ena_o),
    .st_o        (irq_st_o)
  );

  assign irq_o = |irq_st_o;

  AST_RX_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_i |=> irq_raw_o[SRC_RX_DONE]); // R7
  AST_TX_DONE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> irq_raw_o[SRC_TX_DONE]); // R7
  AST_IDLE_NO_HUNG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmo_en_i && !irq_raw_o[SRC_RX_HUNG]) |=> !irq_raw_o[SRC_RX_HUNG]); // R5
endmodule

// File: tb/fifo_stall_irq_bench.sv
module fifo_stall_irq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       rx_done, tx_done, tmo_en, ena_we, clr_we;
  logic [1:0] act, xfer, drst;
  logic [7:0] thr;
  logic [2:0] shift;
  logic [3:0] ena_d, clr_d, raw, ena_q, st;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;

  fifo_stall_irq u_fifo_stall_irq (
    .clk_i(clk), .rst_ni(rst_n), .rx_done_i(rx_done), .tx_done_i(tx_done),
    .dir_act_i(act), .fifo_xfer_i(xfer), .dir_rst_i(drst),
    .tmo_en_i(tmo_en), .tmo_thr_i(thr), .tmo_shift_i(shift),
    .irq_ena_we_i(ena_we), .irq_ena_i(ena_d), .irq_clr_we_i(clr_we), .irq_clr_i(clr_d),
    .irq_raw_o(raw), .irq_ena_o(ena_q), .irq_st_o(st), .irq_o(irq)
  );

  // [20]rx_done [19]tx_done [18]ena_we [17:14]ena [13]clr_we [12:9]clr
  // [8:5]exp raw [4:1]exp st [0]exp irq
  localparam int NV = 10;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1,1'b0, 1'b0,4'b0000, 1'b0,4'b0000, 4'b0001,4'b0000,1'b0}, // R7 masked
    {1'b0,1'b0, 1'b1,4'b0001, 1'b0,4'b0000, 4'b0001,4'b0001,1'b1}, // R8
    {1'b0,1'b1, 1'b0,4'b0000, 1'b0,4'b0000, 4'b0011,4'b0001,1'b1}, // R7
    {1'b0,1'b0, 1'b0,4'b0000, 1'b1,4'b0001, 4'b0010,4'b0000,1'b0}, // R9
    {1'b0,1'b0, 1'b0,4'b0000, 1'b1,4'b0000, 4'b0010,4'b0000,1'b0}, // R9 zeros
    {1'b0,1'b0, 1'b1,4'b0010, 1'b0,4'b0000, 4'b0010,4'b0010,1'b1}, // R8
    {1'b0,1'b1, 1'b0,4'b0000, 1'b1,4'b0010, 4'b0010,4'b0010,1'b1}, // R10
    {1'b0,1'b0, 1'b0,4'b0000, 1'b1,4'b1111, 4'b0000,4'b0000,1'b0}, // R9
    {1'b1,1'b1, 1'b1,4'b0000, 1'b0,4'b0000, 4'b0011,4'b0000,1'b0}, // R8
    {1'b0,1'b0, 1'b0,4'b0000, 1'b1,4'b0011, 4'b0000,4'b0000,1'b0}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_we = 1'b1; clr_d = 4'b1111;
    step(1);
    clr_we = 1'b0; clr_d = 4'b0000;
  endtask

  task automatic pulse_xfer(input int d);
    xfer[d] = 1'b1; step(1); xfer[d] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rx_done = 0; tx_done = 0; tmo_en = 1; ena_we = 0; clr_we = 0;
    act = 0; xfer = 0; drst = 0; thr = 8'd3; shift = 3'd7; ena_d = 0; clr_d = 0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 raw", raw, 0);
    chk("R1 ena", ena_q, 0);
    chk("R1 st", st, 0);
    chk("R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      rx_done = VEC[i][20]; tx_done = VEC[i][19];
      ena_we = VEC[i][18]; ena_d = VEC[i][17:14];
      clr_we = VEC[i][13]; clr_d = VEC[i][12:9];
      step(1);
      rx_done = 0; tx_done = 0; ena_we = 0; clr_we = 0; ena_d = 0; clr_d = 0;
      chk("R7/R8/R9/R10 raw", raw, VEC[i][8:5]);
      chk("R8 st", st, VEC[i][4:1]);
      chk("R8 irq", irq, VEC[i][0]);
    end

    // shift 7: limit 687, period 688; hung set between ~1378 and ~2066 cycles
    ena_we = 1; ena_d = 4'b1111; step(1); ena_we = 0;
    act[0] = 1'b1;
    step(1300);
    chk("R3 rx hung early", raw[2], 0);
    step(800);
    chk("R3 rx hung", raw[2], 1);
    chk("R8 irq hung", irq, 1);
    chk("R11 tx untouched", raw[3], 0);

    clear_all();
    chk("R9 hung cleared", raw[2], 0);
    step(2100);
    chk("R6 no repeat", raw[2], 0);

    for (int k = 0; k < 10; k++) begin
      pulse_xfer(0);
      step(499);
    end
    chk("R4 xfer keeps quiet", raw[2], 0);
    step(2100);
    chk("R6 refire after activity", raw[2], 1);
    act[0] = 1'b0;
    clear_all();

    act[1] = 1'b1;
    step(1300);
    drst[1] = 1'b1; step(1); drst[1] = 1'b0;
    step(1300);
    chk("R4 dir reset restart", raw[3], 0);
    step(800);
    chk("R3 tx hung", raw[3], 1);
    chk("R11 rx untouched", raw[2], 0);
    act[1] = 1'b0;
    clear_all();

    tmo_en = 1'b0; act = 2'b11;
    step(3000);
    chk("R5 disabled", raw[3:2], 0);
    tmo_en = 1'b1; act = 2'b00;
    step(3000);
    chk("R5 inactive", raw[3:2], 0);

    // shift 6: limit 1375, period 1376; hung between ~2754 and ~4130
    shift = 3'd6; act[0] = 1'b1;
    step(2100);
    chk("R2 shift6 early", raw[2], 0);
    step(2100);
    chk("R2 shift6 hung", raw[2], 1);
    act[0] = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule